// File: doc/BRIEF.md
# PHY Management Command Engine

This block lets a host reach the registers of an Ethernet PHY through four host-visible registers: a control register, a command register, a write-data register and a read-data register. The host loads the write-data register if needed, then writes a command word that names a PHY address, a PHY register number and an operation, with a start flag. The engine performs that single read or write against an attached PHY register file. Each command finishes in a fixed latency of two clock edges, and busy and done outputs show when it has finished.

The PHY register file is part of the block. It sits at a parameter address and has fixed reset contents. Several of its registers are computed rather than stored. The status and diagnostic registers follow a link input. The link-partner register and the speed/duplex diagnostics are derived from whatever the host last wrote into the local advertisement register, so a management driver sees a partner that always agrees with its own advertisement. The serial management waveform, clock division and real autonegotiation are not modelled. The divisor field of the control register is only checked for the zero-while-enabled error.

Top module: `mgmt_cmd_engine`

## Requirements
- R1: In the command word, the PHY address is bits 28:24, the register number is bits 20:16, the operation is bits 15:14 and the start flag is bit 11. A command write with bit 11 clear starts nothing: busy stays low and the read-data register keeps its value.
- R2: Operation 1 (write) stores the low 16 bits of the write-data register (host register 2) into the addressed PHY register.
- R3: Operation 2 (read) loads the addressed PHY register into the read-data register (host register 3), whose bits 31:16 always read zero. Operations 0 and 3 access nothing: the read-data register and the PHY contents stay unchanged.
- R4: A read aimed at any PHY address other than PHY_ADDR (default 7) returns 0xFFFF. A write aimed at such an address changes nothing.
- R5: Reading the command register (host register 1) returns the last written word with bit 7 forced to one.
- R6: The control register (host register 0) keeps only bits 6:0, and bits 31:7 read zero. div_err_o is high exactly while bit 6 (enable) is set and bits 5:0 (divisor) are zero.
- R7: After reset, PHY registers 0, 2, 3 and 4 hold 0x3100, 0x0300, 0xE400 and 0x01E1.
- R8: PHY register 1 reads 0x782E while link_up_i is high and 0x0000 while it is low.
- R9: PHY register 5 reads 0x4000 OR (register 4 AND 0x01E0) OR 0x0001.
- R10: PHY register 18 reads 0 while the link is down. While the link is up, bit 10 is set when register 4 has bit 7 or bit 8 set, and bit 11 is set when register 4 has bit 8 or bit 6 set. All other bits are zero.
- R11: PHY register 17 always reads 0x8000.
- R12: After any write to the PHY, bit 15 of PHY register 0 is zero.
- R13: A started command raises busy_o for one cycle after the start edge, then done_o for one cycle, and the access takes effect at that second edge. A start that arrives while busy_o is high is ignored. Host reads return data on host_rdata_o one cycle after host_rd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe |
| host_addr_i | input | 2 | Host register select: 0 control, 1 command, 2 write data, 3 read data |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Registered host read data |
| busy_o | output | 1 | Command in flight |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Interface enabled with a zero clock divisor |
| link_up_i | input | 1 | PHY link state feeding the status and diagnostic registers |

## Verification
On every cycle, the assertions check the busy-then-done handshake, that a command write without the start flag never raises busy, the ready bit on command readback, the zero upper bits of the control and read-data registers, and that an enabled zero divisor raises the error flag. Only the bench scenarios can show the PHY side. That covers the reset contents, the link-dependent status and diagnostics, and the partner and diagnostic values derived from several advertisement patterns. It also covers the reset-bit self-clear, the 0xFFFF answer from an absent address, the operation codes that access nothing, and a second start issued during busy being dropped.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    localparam int PHY_AW        = 5;
    localparam int REG_AW        = 5;
    localparam int PHY_DW        = 16;
    localparam int HOST_DW       = 32;
    localparam int HOST_AW       = 2;
    localparam int CMD_PHY_LSB   = 24;
    localparam int CMD_REG_LSB   = 16;
    localparam int CMD_OP_LSB    = 14;
    localparam int CMD_GO_BIT    = 11;
    localparam int CMD_READY_BIT = 7;
    localparam int CTRL_W        = 7;
    localparam int CTRL_EN_BIT   = 6;

    typedef enum logic [1:0] {
        OP_NOP_A = 2'd0,
        OP_WR    = 2'd1,
        OP_RD    = 2'd2,
        OP_NOP_B = 2'd3
    } mgmt_op_e;

    typedef enum logic [HOST_AW-1:0] {
        HREG_CTRL  = 2'd0,
        HREG_CMD   = 2'd1,
        HREG_WDATA = 2'd2,
        HREG_RDATA = 2'd3
    } host_reg_e;

    typedef struct packed {
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regn;
        mgmt_op_e          op;
        logic [PHY_DW-1:0] wdata;
    } mgmt_req_t;
endpackage

// File: rtl/mgmt_host_regs.sv
module mgmt_host_regs
    import mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr_i,
    input  logic                 host_rd_i,
    input  logic [HOST_AW-1:0]   host_addr_i,
    input  logic [HOST_DW-1:0]   host_wdata_i,
    output logic [HOST_DW-1:0]   host_rdata_o,
    output logic                 launch_o,
    output mgmt_req_t            req_o,
    input  logic                 load_i,
    input  logic [PHY_DW-1:0]    load_data_i,
    output logic                 div_err_o
);
    typedef struct packed {
        logic [CTRL_W-1:0]  ctrl;
        logic [HOST_DW-1:0] cmd;
        logic [PHY_DW-1:0]  wdata;
        logic [PHY_DW-1:0]  rdata;
        logic [HOST_DW-1:0] rdout;
    } hregs_t;

    hregs_t    regs_q, regs_d;
    host_reg_e sel;

    assign sel = host_reg_e'(host_addr_i);

    always_comb begin
        regs_d = regs_q;
        if (host_wr_i) begin
            unique case (sel)
                HREG_CTRL:  regs_d.ctrl  = host_wdata_i[CTRL_W-1:0];
                HREG_CMD:   regs_d.cmd   = host_wdata_i;
                HREG_WDATA: regs_d.wdata = host_wdata_i[PHY_DW-1:0];
                HREG_RDATA: regs_d.rdata = host_wdata_i[PHY_DW-1:0];
            endcase
        end
        if (load_i) begin
            regs_d.rdata = load_data_i;
        end
        if (host_rd_i) begin
            unique case (sel)
                HREG_CTRL:  regs_d.rdout = HOST_DW'(regs_q.ctrl);
                HREG_CMD:   regs_d.rdout = regs_q.cmd | (HOST_DW'(1) << CMD_READY_BIT);
                HREG_WDATA: regs_d.rdout = HOST_DW'(regs_q.wdata);
                HREG_RDATA: regs_d.rdout = HOST_DW'(regs_q.rdata);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign launch_o     = host_wr_i && (sel == HREG_CMD) && host_wdata_i[CMD_GO_BIT];
    assign req_o.phy    = host_wdata_i[CMD_PHY_LSB +: PHY_AW];
    assign req_o.regn   = host_wdata_i[CMD_REG_LSB +: REG_AW];
    assign req_o.op     = mgmt_op_e'(host_wdata_i[CMD_OP_LSB +: 2]);
    assign req_o.wdata  = regs_q.wdata;
    assign host_rdata_o = regs_q.rdout;
    assign div_err_o    = regs_q.ctrl[CTRL_EN_BIT] && (regs_q.ctrl[CTRL_EN_BIT-1:0] == '0);
endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  mgmt_req_t         req_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              phy_we_o,
    output logic              load_o,
    output logic [PHY_AW-1:0] acc_phy_o,
    output logic [REG_AW-1:0] acc_reg_o,
    output logic [PHY_DW-1:0] acc_wdata_o
);
    typedef struct packed {
        logic      busy;
        logic      done;
        mgmt_req_t req;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (seq_q.busy) begin
            seq_d.busy = 1'b0;
            seq_d.done = 1'b1;
        end else if (launch_i) begin
            seq_d.busy = 1'b1;
            seq_d.req  = req_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o      = seq_q.busy;
    assign done_o      = seq_q.done;
    assign phy_we_o    = seq_q.busy && (seq_q.req.op == OP_WR);
    assign load_o      = seq_q.busy && (seq_q.req.op == OP_RD);
    assign acc_phy_o   = seq_q.req.phy;
    assign acc_reg_o   = seq_q.req.regn;
    assign acc_wdata_o = seq_q.req.wdata;
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
    import mgmt_pkg::*;
#(
    parameter logic [PHY_AW-1:0] PHY_ADDR = 5'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up_i,
    input  logic [PHY_AW-1:0] acc_phy_i,
    input  logic [REG_AW-1:0] acc_reg_i,
    input  logic              we_i,
    input  logic [PHY_DW-1:0] wdata_i,
    output logic [PHY_DW-1:0] rdata_o
);
    localparam int NUM_REGS = 1 << REG_AW;

    localparam logic [REG_AW-1:0] IDX_CTL  = REG_AW'(0);
    localparam logic [REG_AW-1:0] IDX_STAT = REG_AW'(1);
    localparam logic [REG_AW-1:0] IDX_ADV  = REG_AW'(4);
    localparam logic [REG_AW-1:0] IDX_LP   = REG_AW'(5);
    localparam logic [REG_AW-1:0] IDX_VEND = REG_AW'(17);
    localparam logic [REG_AW-1:0] IDX_DIAG = REG_AW'(18);

    localparam int CTL_RST_BIT   = 15;
    localparam int ADV_10FD_BIT  = 6;
    localparam int ADV_100HD_BIT = 7;
    localparam int ADV_100FD_BIT = 8;
    localparam int DIAG_SPD_BIT  = 10;
    localparam int DIAG_DPX_BIT  = 11;

    localparam logic [PHY_DW-1:0] STAT_LINK_VAL = 16'h782E;
    localparam logic [PHY_DW-1:0] LP_ACK_VAL    = 16'h4000;
    localparam logic [PHY_DW-1:0] LP_SEL_VAL    = 16'h0001;
    localparam logic [PHY_DW-1:0] ADV_MODE_MASK = 16'h01E0;
    localparam logic [PHY_DW-1:0] VEND_VAL      = 16'h8000;

    function automatic logic [PHY_DW-1:0] rst_val(input int idx);
        case (idx)
            0:       return 16'h3100;
            2:       return 16'h0300;
            3:       return 16'hE400;
            4:       return 16'h01E1;
            default: return '0;
        endcase
    endfunction

    logic [PHY_DW-1:0] regs_q [NUM_REGS];
    logic [PHY_DW-1:0] regs_d [NUM_REGS];
    logic              present;
    logic [PHY_DW-1:0] adv;
    logic              adv_100;
    logic              adv_fd;
    logic [PHY_DW-1:0] view;

    assign present = (acc_phy_i == PHY_ADDR);
    assign adv     = regs_q[IDX_ADV];
    assign adv_100 = adv[ADV_100HD_BIT] | adv[ADV_100FD_BIT];
    assign adv_fd  = adv[ADV_100FD_BIT] | adv[ADV_10FD_BIT];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we_i && present) begin
            regs_d[acc_reg_i]           = wdata_i;
            regs_d[IDX_CTL][CTL_RST_BIT] = 1'b0;
        end

        case (acc_reg_i)
            IDX_STAT: view = link_up_i ? STAT_LINK_VAL : '0;
            IDX_LP:   view = LP_ACK_VAL | (adv & ADV_MODE_MASK) | LP_SEL_VAL;
            IDX_VEND: view = VEND_VAL;
            IDX_DIAG: view = link_up_i
                           ? ((PHY_DW'(adv_100) << DIAG_SPD_BIT) | (PHY_DW'(adv_fd) << DIAG_DPX_BIT))
                           : '0;
            default:  view = regs_q[acc_reg_i];
        endcase
        rdata_o = present ? view : '1;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= rst_val(g);
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end
endmodule

// File: rtl/mgmt_cmd_engine.sv
module mgmt_cmd_engine
    import mgmt_pkg::*;
#(
    parameter logic [PHY_AW-1:0] PHY_ADDR = 5'd7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_i,
    input  logic               host_rd_i,
    input  logic [HOST_AW-1:0] host_addr_i,
    input  logic [HOST_DW-1:0] host_wdata_i,
    output logic [HOST_DW-1:0] host_rdata_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               div_err_o,
    input  logic               link_up_i
);
    mgmt_req_t         req;
    logic              launch;
    logic              phy_we;
    logic              load;
    logic [PHY_AW-1:0] acc_phy;
    logic [REG_AW-1:0] acc_reg;
    logic [PHY_DW-1:0] acc_wdata;
    logic [PHY_DW-1:0] phy_rdata;

    mgmt_host_regs u_host (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_i    (host_wr_i),
        .host_rd_i    (host_rd_i),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o),
        .launch_o     (launch),
        .req_o        (req),
        .load_i       (load),
        .load_data_i  (phy_rdata),
        .div_err_o    (div_err_o)
    );

    mgmt_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .req_i       (req),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .phy_we_o    (phy_we),
        .load_o      (load),
        .acc_phy_o   (acc_phy),
        .acc_reg_o   (acc_reg),
        .acc_wdata_o (acc_wdata)
    );

    mgmt_phy_regs #(.PHY_ADDR(PHY_ADDR)) u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up_i (link_up_i),
        .acc_phy_i (acc_phy),
        .acc_reg_i (acc_reg),
        .we_i      (phy_we),
        .wdata_i   (acc_wdata),
        .rdata_o   (phy_rdata)
    );
endmodule

// File: rtl/mgmt_cmd_engine_sva.sv
module mgmt_cmd_engine_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr_i,
    input logic        host_rd_i,
    input logic [1:0]  host_addr_i,
    input logic [31:0] host_wdata_i,
    input logic [31:0] host_rdata_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        div_err_o
);
    AST_BUSY_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o && done_o)); // R13

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R13

    AST_NO_START_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && host_addr_i == 2'd1 && !host_wdata_i[11] && !busy_o) |=> !busy_o); // R1

    AST_CMD_READY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && host_addr_i == 2'd1) |=> host_rdata_o[7]); // R5

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && host_addr_i == 2'd0) |=> (host_rdata_o[31:7] == '0)); // R6

    AST_ZERO_DIV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && host_addr_i == 2'd0 && host_wdata_i[6] && host_wdata_i[5:0] == '0) |=> div_err_o); // R6

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && host_addr_i == 2'd3) |=> (host_rdata_o[31:16] == '0)); // R3
endmodule

bind mgmt_cmd_engine mgmt_cmd_engine_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_i    (host_wr_i),
    .host_rd_i    (host_rd_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .div_err_o    (div_err_o)
);

// File: tb/tb_mgmt_cmd_engine.sv
module tb_mgmt_cmd_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy, done, div_err;
    logic        link_up = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_flag = 1'b0;
    logic [31:0] mon_exp;
    string       mon_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_cmd_engine dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_i    (host_wr),
        .host_rd_i    (host_rd),
        .host_addr_i  (host_addr),
        .host_wdata_i (host_wdata),
        .host_rdata_o (host_rdata),
        .busy_o       (busy),
        .done_o       (done),
        .div_err_o    (div_err),
        .link_up_i    (link_up)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected read value one cycle after each host read.
    always @(posedge clk) rd_flag <= host_rd;
    always @(negedge clk) begin
        if (rd_flag) begin
            if (exp_q.size() == 0) begin
                chk("R13 unexpected read", host_rdata, 32'hDEAD_BEEF);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                chk(mon_tag, host_rdata, mon_exp);
            end
        end
    end

    function automatic logic [31:0] mk_cmd(input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [1:0] op, input logic go);
        return (32'(phy) << 24) | (32'(rg) << 16) | (32'(op) << 14) | (32'(go) << 11);
    endfunction

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic run_cmd(input logic [4:0] phy, input logic [4:0] rg, input logic [1:0] op);
        host_write(2'd1, mk_cmd(phy, rg, op, 1'b1));
        chk("R13 busy after start", {30'd0, busy, done}, 32'h2);
        @(negedge clk);
        chk("R13 done after busy", {30'd0, busy, done}, 32'h1);
    endtask

    task automatic phy_read(input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] exp, input string tag);
        run_cmd(phy, rg, 2'd2);
        host_read(2'd3, 32'(exp), tag);
    endtask

    task automatic phy_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v);
        host_write(2'd2, 32'(v));
        run_cmd(phy, rg, 2'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 reset busy/done", {30'd0, busy, done}, 32'h0);
        chk("R6 reset div_err", 32'(div_err), 32'h0);
        host_read(2'd0, 32'h0, "R6 reset control");
        host_read(2'd3, 32'h0, "R3 reset read data");

        // Reset contents
        phy_read(5'd7, 5'd0, 16'h3100, "R7 reg0 reset");
        phy_read(5'd7, 5'd2, 16'h0300, "R7 reg2 reset");
        phy_read(5'd7, 5'd3, 16'hE400, "R7 reg3 reset");
        phy_read(5'd7, 5'd4, 16'h01E1, "R7 reg4 reset");

        // Link dependent status and diagnostics
        phy_read(5'd7, 5'd1, 16'h782E, "R8 status link up");
        phy_read(5'd7, 5'd18, 16'h0C00, "R10 diag default adv");
        @(negedge clk); link_up = 1'b0;
        phy_read(5'd7, 5'd1, 16'h0000, "R8 status link down");
        phy_read(5'd7, 5'd18, 16'h0000, "R10 diag link down");
        @(negedge clk); link_up = 1'b1;
        phy_read(5'd7, 5'd17, 16'h8000, "R11 vendor constant");
        phy_read(5'd7, 5'd5, 16'h41E1, "R9 partner default");

        // Advertisement patterns
        phy_write(5'd7, 5'd4, 16'h0021);
        phy_read(5'd7, 5'd4, 16'h0021, "R2 adv written");
        phy_read(5'd7, 5'd5, 16'h4021, "R9 partner 10 half");
        phy_read(5'd7, 5'd18, 16'h0000, "R10 diag 10 half");
        phy_write(5'd7, 5'd4, 16'h0041);
        phy_read(5'd7, 5'd18, 16'h0800, "R10 diag 10 full");
        phy_write(5'd7, 5'd4, 16'h0081);
        phy_read(5'd7, 5'd18, 16'h0400, "R10 diag 100 half");
        phy_read(5'd7, 5'd5, 16'h4081, "R9 partner 100 half");

        // Reset bit self-clear
        phy_write(5'd7, 5'd0, 16'h9140);
        phy_read(5'd7, 5'd0, 16'h1140, "R12 reset bit cleared");

        // Absent PHY address
        phy_read(5'd3, 5'd2, 16'hFFFF, "R4 absent read");
        phy_write(5'd3, 5'd4, 16'h5555);
        phy_read(5'd7, 5'd4, 16'h0081, "R4 absent write ignored");

        // Operations that access nothing
        host_write(2'd3, 32'h0000_1234);
        run_cmd(5'd7, 5'd2, 2'd0);
        host_read(2'd3, 32'h1234, "R3 op0 leaves read data");
        host_write(2'd2, 32'h0000_AAAA);
        run_cmd(5'd7, 5'd4, 2'd3);
        host_read(2'd3, 32'h1234, "R3 op3 leaves read data");
        phy_read(5'd7, 5'd4, 16'h0081, "R3 op3 leaves phy");

        // Start flag clear
        host_write(2'd3, 32'h0000_00AB);
        host_write(2'd1, mk_cmd(5'd7, 5'd3, 2'd2, 1'b0));
        chk("R1 no start no busy", {30'd0, busy, done}, 32'h0);
        @(negedge clk);
        chk("R1 no start no done", {30'd0, busy, done}, 32'h0);
        host_read(2'd3, 32'h00AB, "R1 no start read data kept");

        // Command readback
        host_read(2'd1, mk_cmd(5'd7, 5'd3, 2'd2, 1'b0) | 32'h80, "R5 cmd readback");
        host_write(2'd1, 32'h0);
        host_read(2'd1, 32'h80, "R5 ready bit on zero cmd");

        // Control register
        host_write(2'd0, 32'hFFFF_FF45);
        host_read(2'd0, 32'h45, "R6 control masked");
        chk("R6 no div error", 32'(div_err), 32'h0);
        host_write(2'd0, 32'h40);
        chk("R6 div error", 32'(div_err), 32'h1);
        host_read(2'd0, 32'h40, "R6 control enable only");

        // Start while busy is ignored
        @(negedge clk);
        host_wr = 1'b1; host_addr = 2'd1; host_wdata = mk_cmd(5'd7, 5'd2, 2'd2, 1'b1);
        @(negedge clk);
        chk("R13 first start busy", {30'd0, busy, done}, 32'h2);
        host_wdata = mk_cmd(5'd7, 5'd3, 2'd2, 1'b1);
        @(negedge clk);
        host_wr = 1'b0;
        chk("R13 busy start dropped", {30'd0, busy, done}, 32'h1);
        @(negedge clk);
        chk("R13 no second busy", {30'd0, busy, done}, 32'h0);
        host_read(2'd3, 32'h0300, "R13 first command result");

        repeat (3) @(negedge clk);
        chk("R13 scoreboard drained", 32'(exp_q.size()), 32'h0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL R13 watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule